// File: doc/BRIEF.md
# Synthesizer Calibration Sequencer

This block decides when a frequency synthesizer runs its self-calibration and whether the calibration produced a usable PLL lock. Software can start a calibration directly with a strobe, but only while the sequencer is idle. The block can also calibrate on its own, either each time the synthesizer is switched on or each time it is switched off. A two-bit mode input selects which of these applies, or neither.

Each calibration attempt takes a programmable number of clock cycles. On the last cycle of an attempt the sequencer samples a status code from the analog side. The all-ones code means the loop failed to lock. In that case another attempt starts at once. After a bounded number of attempts the sequencer gives up and raises an error. A needs-calibration flag is set at power-up and whenever a frequency setting is written. Only a locked calibration clears it. Sleep leaves the flag and the lock indicator alone, so a calibration stays valid after waking.

Top module: `fs_cal_seq`

## Requirements
- R1: After reset, cal_needed is 1 and cal_start, cal_busy, pll_lock and cal_error are 0.
- R2: A cal_strobe pulse while idle starts a calibration in every mode. cal_start is high for exactly one cycle, in the cycle after the strobe, and cal_busy rises in that same cycle.
- R3: cal_strobe is ignored while the synthesizer is running, while asleep and while a calibration is in progress. No cal_start pulse follows it.
- R4: auto_mode selects automatic calibration as follows. 2'b01 calibrates on a turn-on request from idle and ends in the running state. 2'b10 calibrates on a turn-off request while running and ends in idle. 2'b00 and 2'b11 make both transitions without calibrating.
- R5: cal_status is sampled in the last busy cycle of an attempt. 6'h3F means no lock; any other value means lock. After a locked attempt, pll_lock rises in the cycle after the last busy cycle. pll_lock is cleared whenever a calibration starts.
- R6: When an attempt ends without lock and fewer than MAX_TRIES (default 8) attempts have been made, a new attempt starts at once with a new cal_start pulse. cal_busy stays high across the boundary between attempts.
- R7: When MAX_TRIES attempts in a row fail, cal_error becomes 1, pll_lock stays 0 and cal_busy falls. cal_error is cleared when the next calibration starts.
- R8: Each attempt keeps cal_busy high for exactly cal_time cycles. A cal_time of 0 is treated as 1.
- R9: Entering sleep (sleep_req while idle) and leaving it (wake_req) changes neither cal_needed nor pll_lock.
- R10: A freq_write pulse sets cal_needed and clears pll_lock. Only a locked calibration clears cal_needed. If a write and a locked completion fall in the same cycle, the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_mode | input | 2 | Automatic calibration mode (00 none, 01 on turn-on, 10 on turn-off, 11 none) |
| cal_strobe | input | 1 | Manual calibration strobe |
| fs_on_req | input | 1 | Request to turn the synthesizer on |
| fs_off_req | input | 1 | Request to turn the synthesizer off |
| sleep_req | input | 1 | Enter sleep from idle |
| wake_req | input | 1 | Leave sleep |
| freq_write | input | 1 | A frequency setting was written |
| cal_time | input | CNT_W | Cycles per calibration attempt |
| cal_status | input | STAT_W | Lock status code from the synthesizer |
| cal_start | output | 1 | One-cycle pulse at the start of each attempt |
| cal_busy | output | 1 | A calibration is in progress |
| pll_lock | output | 1 | Lock indicator |
| cal_needed | output | 1 | Calibration is required |
| cal_error | output | 1 | Retry limit reached without lock |

## Verification
Each internal fault shows up at a port within a known number of cycles.
- An attempt counter that is off by one changes the number of cal_start pulses in a failed run. It also moves the cycle in which cal_error rises.
- A wrong cycle count in the timer changes the gap between start pulses, so the fault appears within the first attempt.
- If the state register holds the wrong return state, the next turn-on or turn-off request either calibrates when it should not or skips a calibration. This is visible one cycle after the request.
- A flag that sleep disturbs, or that a failed attempt clears, is visible on cal_needed or pll_lock as soon as the sequencer is idle again.

// File: rtl/fs_cal_pkg.sv
package fs_cal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_CAL   = 2'd2,
    ST_SLEEP = 2'd3
  } seq_state_t;

  typedef enum logic [1:0] {
    AC_NONE = 2'b00,
    AC_ON   = 2'b01,
    AC_OFF  = 2'b10,
    AC_RSVD = 2'b11
  } autocal_t;
endpackage

// File: rtl/fs_cal_timer.sv
module fs_cal_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = (load_val == '0) ? CNT_W'(1) : load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = (cnt_q == CNT_W'(1));

  // R8
  load_arms_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q != '0));
endmodule

// File: rtl/fs_cal_retry.sv
module fs_cal_retry #(
  parameter int MAX_TRIES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic first,
  input  logic again,
  output logic last_try
);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam logic [TRY_W-1:0] LIMIT = TRY_W'(MAX_TRIES);

  logic [TRY_W-1:0] try_q, try_d;
  logic             try_en;

  always_comb begin
    try_en = first | again;
    try_d  = first ? TRY_W'(1) : try_q + TRY_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      try_q <= '0;
    else if (try_en) try_q <= try_d;
  end

  assign last_try = (try_q == LIMIT);

  // R6
  try_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    try_q <= LIMIT);
endmodule

// File: rtl/fs_cal_seq.sv
module fs_cal_seq
  import fs_cal_pkg::*;
#(
  parameter int                CNT_W     = 8,
  parameter int                STAT_W    = 6,
  parameter int                MAX_TRIES = 8,
  parameter logic [STAT_W-1:0] NO_LOCK   = {STAT_W{1'b1}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        auto_mode,
  input  logic              cal_strobe,
  input  logic              fs_on_req,
  input  logic              fs_off_req,
  input  logic              sleep_req,
  input  logic              wake_req,
  input  logic              freq_write,
  input  logic [CNT_W-1:0]  cal_time,
  input  logic [STAT_W-1:0] cal_status,
  output logic              cal_start,
  output logic              cal_busy,
  output logic              pll_lock,
  output logic              cal_needed,
  output logic              cal_error
);
  seq_state_t state_q, state_d, ret_q, ret_d;
  autocal_t   mode;
  logic       start_q, lock_q, need_q, err_q;
  logic       start_d, lock_d, need_d, err_d;
  logic       kick, retry, expire, last_try, lock_ok, done_ok, done_bad;

  assign mode    = autocal_t'(auto_mode);
  assign lock_ok = (cal_status != NO_LOCK);

  fs_cal_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(kick | retry),
    .load_val(cal_time), .expire(expire)
  );

  fs_cal_retry #(.MAX_TRIES(MAX_TRIES)) u_retry (
    .clk(clk), .rst_n(rst_n), .first(kick), .again(retry),
    .last_try(last_try)
  );

  always_comb begin
    state_d  = state_q;
    ret_d    = ret_q;
    kick     = 1'b0;
    retry    = 1'b0;
    done_ok  = 1'b0;
    done_bad = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cal_strobe) begin
          kick  = 1'b1;
          ret_d = ST_IDLE;
        end else if (fs_on_req) begin
          if (mode == AC_ON) begin
            kick  = 1'b1;
            ret_d = ST_RUN;
          end else begin
            state_d = ST_RUN;
          end
        end else if (sleep_req) begin
          state_d = ST_SLEEP;
        end
      end
      ST_RUN: begin
        if (fs_off_req) begin
          if (mode == AC_OFF) begin
            kick  = 1'b1;
            ret_d = ST_IDLE;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_CAL: begin
        if (expire) begin
          if (lock_ok) begin
            done_ok = 1'b1;
            state_d = ret_q;
          end else if (last_try) begin
            done_bad = 1'b1;
            state_d  = ret_q;
          end else begin
            retry = 1'b1;
          end
        end
      end
      ST_SLEEP: begin
        if (wake_req) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    if (kick) state_d = ST_CAL;

    start_d = kick | retry;
    lock_d  = (freq_write | kick) ? 1'b0 : (done_ok ? 1'b1 : lock_q);
    need_d  = freq_write ? 1'b1 : (done_ok ? 1'b0 : need_q);
    err_d   = kick ? 1'b0 : (done_bad ? 1'b1 : err_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ret_q   <= ST_IDLE;
      start_q <= 1'b0;
      lock_q  <= 1'b0;
      need_q  <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (kick) ret_q <= ret_d;
      start_q <= start_d;
      lock_q  <= lock_d;
      need_q  <= need_d;
      err_q   <= err_d;
    end
  end

  assign cal_start  = start_q;
  assign cal_busy   = (state_q == ST_CAL);
  assign pll_lock   = lock_q;
  assign cal_needed = need_q;
  assign cal_error  = err_q;

  // R2
  start_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> cal_busy);

  // R8
  busy_ends_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cal_busy) |-> $past(expire));

  // R5
  lock_rise_after_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_lock) |-> ($past(cal_busy) && !cal_needed));

  // R7
  error_excludes_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_error |-> !pll_lock);

  // R3
  strobe_in_run_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && cal_strobe && !fs_off_req) |=> !cal_start);
endmodule

// File: tb/fs_cal_seq_tb.sv
`timescale 1ns/1ps
module fs_cal_seq_tb;
  localparam int CNT_W = 8;
  localparam int STAT_W = 6;
  localparam int MAX_TRIES = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] auto_mode = 2'b00;
  logic cal_strobe = 0, fs_on_req = 0, fs_off_req = 0;
  logic sleep_req = 0, wake_req = 0, freq_write = 0;
  logic [CNT_W-1:0] cal_time = 8'd4;
  logic [STAT_W-1:0] cal_status = 6'h15;
  logic cal_start, cal_busy, pll_lock, cal_needed, cal_error;

  int checks = 0;
  int errors = 0;
  int fails_left = 0;
  int exp_q[$];
  bit finished = 0;

  always #2.5 clk = ~clk;

  fs_cal_seq #(.CNT_W(CNT_W), .STAT_W(STAT_W), .MAX_TRIES(MAX_TRIES)) u_dut (
    .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .cal_strobe(cal_strobe),
    .fs_on_req(fs_on_req), .fs_off_req(fs_off_req), .sleep_req(sleep_req),
    .wake_req(wake_req), .freq_write(freq_write), .cal_time(cal_time),
    .cal_status(cal_status), .cal_start(cal_start), .cal_busy(cal_busy),
    .pll_lock(pll_lock), .cal_needed(cal_needed), .cal_error(cal_error)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Monitor: pops one expected duration per cal_start and measures busy
  int  mon_cnt = 0;
  int  mon_exp = 0;
  bit  mon_act = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (cal_start) begin
        if (mon_act) chk("R8 attempt length", mon_cnt, mon_exp);
        if (exp_q.size() == 0) begin
          chk("R3 unexpected cal_start", 1, 0);
          mon_exp = 0;
        end else begin
          mon_exp = exp_q.pop_front();
        end
        mon_act = 1;
        mon_cnt = 1;
        if (fails_left > 0) begin
          cal_status = 6'h3F;
          fails_left--;
        end else begin
          cal_status = 6'h15;
        end
      end else if (mon_act && cal_busy) begin
        mon_cnt++;
      end else if (mon_act) begin
        chk("R8 attempt length", mon_cnt, mon_exp);
        mon_act = 0;
      end
    end
  end

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // which: 0 strobe, 1 turn-on, 2 turn-off, 3 write, 4 sleep, 5 wake
  task automatic pulse(input int which);
    case (which)
      0: cal_strobe = 1;
      1: fs_on_req = 1;
      2: fs_off_req = 1;
      3: freq_write = 1;
      4: sleep_req = 1;
      default: wake_req = 1;
    endcase
    @(negedge clk);
    cal_strobe = 0; fs_on_req = 0; fs_off_req = 0;
    freq_write = 0; sleep_req = 0; wake_req = 0;
  endtask

  // Driver: pushes expected attempt lengths, triggers, waits for completion
  task automatic run_cal(input int which, input int n, input int fails, input string tag);
    int tries = (fails + 1 > MAX_TRIES) ? MAX_TRIES : fails + 1;
    int dur = (n == 0) ? 1 : n;
    cal_time = CNT_W'(n);
    fails_left = fails;
    for (int i = 0; i < tries; i++) exp_q.push_back(dur);
    pulse(which);
    chk({tag, " busy after trigger"}, int'(cal_busy), 1);
    chk({tag, " start pulse"}, int'(cal_start), 1);
    for (int i = 0; i < 2000 && cal_busy; i++) @(negedge clk);
    @(negedge clk);
    fails_left = 0;
  endtask

  initial begin
    #200000;
    chk("watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    idle_cycles(3);
    // R1 reset state
    chk("R1 cal_needed", int'(cal_needed), 1);
    chk("R1 pll_lock", int'(pll_lock), 0);
    chk("R1 cal_busy", int'(cal_busy), 0);
    chk("R1 cal_start", int'(cal_start), 0);
    chk("R1 cal_error", int'(cal_error), 0);
    rst_n = 1;
    idle_cycles(2);

    // R2 manual strobe, R5 lock on good status
    auto_mode = 2'b00;
    run_cal(0, 5, 0, "R2");
    chk("R5 lock after good status", int'(pll_lock), 1);
    chk("R10 needed cleared by lock", int'(cal_needed), 0);

    // R4 mode 00: turn-on without calibration; R3 strobe in RUN ignored
    pulse(1);
    idle_cycles(2);
    chk("R4 no cal on turn-on mode 00", int'(cal_busy), 0);
    pulse(0);
    idle_cycles(6);
    chk("R3 strobe ignored while running", int'(cal_busy), 0);
    pulse(2);
    idle_cycles(2);
    chk("R4 no cal on turn-off mode 00", int'(cal_busy), 0);

    // R10 write sets needed, clears lock
    pulse(3);
    chk("R10 needed after write", int'(cal_needed), 1);
    chk("R10 lock cleared by write", int'(pll_lock), 0);

    // R4 mode 01: cal on turn-on
    auto_mode = 2'b01;
    run_cal(1, 3, 0, "R4 on");
    chk("R4 lock after turn-on cal", int'(pll_lock), 1);
    chk("R10 needed cleared", int'(cal_needed), 0);
    pulse(2);
    idle_cycles(2);
    chk("R4 no cal on turn-off mode 01", int'(cal_busy), 0);

    // R4 mode 10 and R6 retries
    auto_mode = 2'b10;
    pulse(1);
    idle_cycles(2);
    chk("R4 no cal on turn-on mode 10", int'(cal_busy), 0);
    run_cal(2, 2, 2, "R6 retry");
    chk("R6 lock after retries", int'(pll_lock), 1);
    chk("R6 no error after retries", int'(cal_error), 0);

    // R4 mode 11 behaves as none
    auto_mode = 2'b11;
    pulse(1);
    idle_cycles(2);
    chk("R4 no cal on turn-on mode 11", int'(cal_busy), 0);
    pulse(2);
    idle_cycles(2);

    // R7 exhaustion
    auto_mode = 2'b00;
    pulse(3);
    run_cal(0, 3, 20, "R7");
    chk("R7 error set", int'(cal_error), 1);
    chk("R7 lock low", int'(pll_lock), 0);
    chk("R7 still needed", int'(cal_needed), 1);
    chk("R7 queue drained", exp_q.size(), 0);

    // R7 error cleared at next start; R8 length 1
    run_cal(0, 1, 0, "R8 len1");
    chk("R7 error cleared", int'(cal_error), 0);
    chk("R5 lock after single cycle", int'(pll_lock), 1);

    // R9 sleep keeps flags; R3 strobe in sleep ignored
    pulse(4);
    idle_cycles(1);
    pulse(0);
    idle_cycles(4);
    chk("R3 strobe ignored asleep", int'(cal_busy), 0);
    pulse(5);
    idle_cycles(2);
    chk("R9 needed kept", int'(cal_needed), 0);
    chk("R9 lock kept", int'(pll_lock), 1);

    // R8 zero treated as one
    run_cal(0, 0, 0, "R8 zero");
    chk("R8 zero queue drained", exp_q.size(), 0);
    chk("R5 lock after zero-length", int'(pll_lock), 1);

    idle_cycles(3);
    finish_run();
  end
endmodule